// File: doc/BRIEF.md
# Chained-Descriptor Byte DMA Channel

This block is a single DMA channel with 24-bit addresses that works through a chain of transfer blocks. Software does not program the source, destination and length of each block directly. It writes the source-address register with the address of a table in memory and then sets the enable input. The table holds one parameter entry for each block. For each block the channel reads the entry, then copies the block's bytes from source to destination, then goes on to the next entry. After the last block it signals completion.

Each data byte waits for a request. On a request the channel reads the byte at the current source address and writes it to the current destination address on the following cycle. The three channel registers serve two purposes. Before a start they return what software wrote. Once the channel is running they show its live state: the next source address, the next destination address and the bytes left in the current block. The memory port is a simple byte-wide master, and read data is taken in the same cycle as the read strobe.

Top module: `chain_dma`

## Requirements
- R1: After reset, busy, done, err, mem_rd and mem_wr are low, and all three registers read back as zero.
- R2: While idle, a write selects its register with reg_sel: 0 is the source address, 1 is the destination address and 2 is the byte count. reg_rdata returns the register that reg_sel selects, and a selector of 3 reads zero. Before a start, a register reads back the value written to it.
- R3: A rising edge of enable starts the channel from the table base held in the source-address register. In the nine cycles that follow the start edge, the channel asserts mem_rd with consecutive addresses base+9n, base+9n+1, ... base+9n+8 for entry n. No mem_wr occurs during these nine cycles.
- R4: A table entry is 9 bytes: offsets 0 to 2 hold the source address, offsets 3 to 5 hold the destination address and offsets 6 to 8 hold the byte count, each least significant byte first. After the fetch, the registers read back the fetched values.
- R5: Each request moves one byte: a mem_rd at the source address, then on the next cycle a mem_wr of that byte at the destination address. Both addresses then increase by one and the count drops by one. Exactly the fetched number of bytes is written.
- R6: When the last block's count reaches zero, done is high for exactly one cycle and busy falls.
- R7: With a block count of N, the channel processes N consecutive table entries in order.
- R8: A start while the count register is zero or the block-count input is zero sets err and leaves the channel idle. A later start that succeeds clears err.
- R9: Clearing enable during a transfer stops the channel after the byte in progress, so busy falls within three cycles. The registers then show the partial progress.
- R10: Register writes while the channel is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read-back of the selected register |
| enable | input | 1 | Rising edge starts the channel; low stops it |
| block_count | input | NBW | Number of table entries to process |
| req | input | 1 | Transfer request, one byte per accepted request |
| mem_addr | output | 24 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of mem_rd |
| busy | output | 1 | Channel is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero count or zero block count seen at start |

## Verification
A table pointer that skips or repeats a step shows up within nine cycles of the start, because the fetch addresses on mem_addr leave their consecutive run. If a byte of an entry lands in the wrong register, the read-back values are wrong as soon as the fetch ends, and the first write then goes to the wrong place. A count that is off by one shows up at completion: either the byte after the block is overwritten or the last byte is never written. A wrong block counter shows up as done arriving one table entry early or late.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int NBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_sel,
  input  logic [23:0]    reg_wdata,
  output logic [23:0]    reg_rdata,
  input  logic           enable,
  input  logic [NBW-1:0] block_count,
  input  logic           req,
  output logic [23:0]    mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [7:0]     mem_wdata,
  input  logic [7:0]     mem_rdata,
  output logic           busy,
  output logic           done,
  output logic           err
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR} st_t;

  st_t            st;
  logic [23:0]    sar, dar, tcr, tp;
  logic [NBW-1:0] blk;
  logic [3:0]     idx;
  logic [7:0]     dbuf;
  logic           en_q;

  assign busy      = (st != S_IDLE);
  assign mem_rd    = (st == S_FETCH) || (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_wdata = dbuf;
  assign mem_addr  = (st == S_FETCH) ? tp : (st == S_WR) ? dar : sar;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = sar;
      2'd1:    reg_rdata = dar;
      2'd2:    reg_rdata = tcr;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sar  <= '0;
      dar  <= '0;
      tcr  <= '0;
      tp   <= '0;
      blk  <= '0;
      idx  <= '0;
      dbuf <= '0;
      en_q <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      en_q <= enable;
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (reg_wr) begin
            case (reg_sel)
              2'd0:    sar <= reg_wdata;
              2'd1:    dar <= reg_wdata;
              2'd2:    tcr <= reg_wdata;
              default: ;
            endcase
          end
          if (enable && !en_q) begin
            if (tcr == '0 || block_count == '0) begin
              err <= 1'b1;
            end else begin
              err <= 1'b0;
              tp  <= sar;
              blk <= block_count;
              idx <= '0;
              st  <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          tp  <= tp + 24'd1;
          idx <= idx + 4'd1;
          case (idx)
            4'd0: sar[7:0]   <= mem_rdata;
            4'd1: sar[15:8]  <= mem_rdata;
            4'd2: sar[23:16] <= mem_rdata;
            4'd3: dar[7:0]   <= mem_rdata;
            4'd4: dar[15:8]  <= mem_rdata;
            4'd5: dar[23:16] <= mem_rdata;
            4'd6: tcr[7:0]   <= mem_rdata;
            4'd7: tcr[15:8]  <= mem_rdata;
            default: begin
              tcr[23:16] <= mem_rdata;
              st         <= S_WAIT;
            end
          endcase
        end
        S_WAIT: begin
          if (!enable) begin
            st <= S_IDLE;
          end else if (tcr == '0) begin
            if (blk == NBW'(1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              blk <= blk - NBW'(1);
              idx <= '0;
              st  <= S_FETCH;
            end
          end else if (req) begin
            st <= S_RD;
          end
        end
        S_RD: begin
          dbuf <= mem_rdata;
          st   <= S_WR;
        end
        default: begin
          sar <= sar + 24'd1;
          dar <= dar + 24'd1;
          tcr <= tcr - 24'd1;
          if (tcr == 24'd1) begin
            if (blk == NBW'(1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              blk <= blk - NBW'(1);
              idx <= '0;
              st  <= S_FETCH;
            end
          end else if (!enable) begin
            st <= S_IDLE;
          end else begin
            st <= S_WAIT;
          end
        end
      endcase
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R3

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && idx != 4'd0) |-> (mem_addr == $past(mem_addr) + 24'd1)); // R3

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |=> (sar == $past(sar) + 24'd1 && tcr == $past(tcr) - 24'd1)); // R5

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy); // R8

endmodule

// File: tb/tb_chain_dma.sv
module tb_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        enable = 1'b0;
  logic [7:0]  block_count = 8'd1;
  logic        req = 1'b0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done, err;

  logic [7:0] mem [0:4095];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chain_dma #(.NBW(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enable(enable),
    .block_count(block_count), .req(req), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err)
  );

  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

  localparam logic [95:0] VEC [4] = '{
    {24'h000040, 24'h000200, 24'h000400, 24'd5},
    {24'h000050, 24'h0003F0, 24'h000500, 24'd1},
    {24'h000060, 24'h000310, 24'h000600, 24'd16},
    {24'h000070, 24'h000700, 24'h000720, 24'd12}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [23:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [23:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic put_entry(input logic [23:0] a, input logic [23:0] s,
                           input logic [23:0] d, input logic [23:0] n);
    for (int k = 0; k < 3; k++) begin
      mem[12'(a + k)]     = s[8*k +: 8];
      mem[12'(a + 3 + k)] = d[8*k +: 8];
      mem[12'(a + 6 + k)] = n[8*k +: 8];
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] s, input int k);
    return 8'(s[7:0] + 8'(k * 7) + 8'd3);
  endfunction

  task automatic prep(input logic [23:0] s, input logic [23:0] d, input int n);
    for (int k = 0; k < n; k++) mem[12'(s + k)] = pat(s, k);
    for (int k = 0; k <= n; k++) mem[12'(d + k)] = 8'hEE;
  endtask

  task automatic check_dst(input string tag, input logic [23:0] s,
                           input logic [23:0] d, input int n);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < n; k++) if (mem[12'(d + k)] !== pat(s, k)) ok = 1'b0;
    chk({tag, " data"}, {31'd0, ok}, 32'd1);
    chk({tag, " no extra byte"}, {24'd0, mem[12'(d + n)]}, 32'h000000EE);
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (done !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen"}, {31'd0, done}, 32'd1);
    @(negedge clk);
    chk({tag, " done one cycle"}, {31'd0, done}, 32'd0);
    chk({tag, " idle after done"}, {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v, t, s, d, n;
    int moved;
    for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    chk("R1 flags", {30'd0, done, err}, 32'd0);
    rd_reg(2'd0, v); chk("R1 src reg", {8'd0, v}, 32'd0);
    rd_reg(2'd2, v); chk("R1 cnt reg", {8'd0, v}, 32'd0);

    // R2 read-back before start
    wr_reg(2'd0, 24'hABCDEF); wr_reg(2'd1, 24'h123456); wr_reg(2'd2, 24'h000777);
    rd_reg(2'd0, v); chk("R2 src readback", {8'd0, v}, 32'h00ABCDEF);
    rd_reg(2'd1, v); chk("R2 dst readback", {8'd0, v}, 32'h00123456);
    rd_reg(2'd2, v); chk("R2 cnt readback", {8'd0, v}, 32'h00000777);
    rd_reg(2'd3, v); chk("R2 unused select", {8'd0, v}, 32'd0);

    // R8 zero count and zero block count
    wr_reg(2'd2, 24'd0);
    enable = 1'b1; @(negedge clk);
    chk("R8 err on zero count", {31'd0, err}, 32'd1);
    chk("R8 idle on zero count", {31'd0, busy}, 32'd0);
    enable = 1'b0; @(negedge clk);
    wr_reg(2'd2, 24'd4); block_count = 8'd0;
    enable = 1'b1; @(negedge clk);
    chk("R8 err on zero blocks", {31'd0, err}, 32'd1);
    chk("R8 idle on zero blocks", {31'd0, busy}, 32'd0);
    enable = 1'b0; block_count = 8'd1; @(negedge clk);

    // R5 R6 vector walk of single blocks
    for (int i = 0; i < 4; i++) begin
      t = VEC[i][95:72]; s = VEC[i][71:48]; d = VEC[i][47:24]; n = VEC[i][23:0];
      put_entry(t, s, d, n);
      prep(s, d, int'(n));
      wr_reg(2'd0, t); wr_reg(2'd2, 24'h00005A);
      block_count = 8'd1; req = 1'b1; enable = 1'b1;
      @(negedge clk);
      wait_done($sformatf("R6 vec%0d", i));
      req = 1'b0; enable = 1'b0;
      check_dst($sformatf("R5 vec%0d", i), s, d, int'(n));
      rd_reg(2'd0, v); chk("R5 src after block", {8'd0, v}, {8'd0, s + n});
      rd_reg(2'd1, v); chk("R5 dst after block", {8'd0, v}, {8'd0, d + n});
      rd_reg(2'd2, v); chk("R5 cnt after block", {8'd0, v}, 32'd0);
      chk("R8 err cleared by good start", {31'd0, err}, 32'd0);
      @(negedge clk);
    end

    // R3 R4 R10 fetch sequence, fetched read-back, writes ignored while busy
    put_entry(24'h0000A0, 24'h000800, 24'h000900, 24'd3);
    prep(24'h000800, 24'h000900, 3);
    wr_reg(2'd0, 24'h0000A0); wr_reg(2'd2, 24'd1);
    enable = 1'b1; @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      chk($sformatf("R3 fetch %0d addr", k), {8'd0, mem_addr}, 32'h000000A0 + 32'(k));
      chk($sformatf("R3 fetch %0d strobes", k), {30'd0, mem_rd, mem_wr}, 32'd2);
      @(negedge clk);
    end
    rd_reg(2'd0, v); chk("R4 fetched src", {8'd0, v}, 32'h00000800);
    rd_reg(2'd1, v); chk("R4 fetched dst", {8'd0, v}, 32'h00000900);
    rd_reg(2'd2, v); chk("R4 fetched cnt", {8'd0, v}, 32'd3);
    wr_reg(2'd0, 24'h123456);
    rd_reg(2'd0, v); chk("R10 write ignored while busy", {8'd0, v}, 32'h00000800);
    req = 1'b1; @(negedge clk); req = 1'b0;
    chk("R5 read strobe at source", {7'd0, mem_rd, mem_addr}, 32'h01000800);
    @(negedge clk);
    chk("R5 write strobe at dest", {7'd0, mem_wr, mem_addr}, 32'h01000900);
    chk("R5 write data", {24'd0, mem_wdata}, {24'd0, pat(24'h000800, 0)});
    @(negedge clk);
    rd_reg(2'd0, v); chk("R5 src step", {8'd0, v}, 32'h00000801);
    rd_reg(2'd1, v); chk("R5 dst step", {8'd0, v}, 32'h00000901);
    rd_reg(2'd2, v); chk("R5 cnt step", {8'd0, v}, 32'd2);
    req = 1'b1;
    wait_done("R6 directed");
    req = 1'b0; enable = 1'b0;
    check_dst("R5 directed", 24'h000800, 24'h000900, 3);
    @(negedge clk);

    // R7 three chained blocks
    put_entry(24'h000100, 24'h000A00, 24'h000B00, 24'd4);
    put_entry(24'h000109, 24'h000A40, 24'h000B40, 24'd7);
    put_entry(24'h000112, 24'h000A80, 24'h000B80, 24'd2);
    prep(24'h000A00, 24'h000B00, 4);
    prep(24'h000A40, 24'h000B40, 7);
    prep(24'h000A80, 24'h000B80, 2);
    wr_reg(2'd0, 24'h000100); wr_reg(2'd2, 24'd9);
    block_count = 8'd3; req = 1'b1; enable = 1'b1;
    @(negedge clk);
    wait_done("R7 chain");
    req = 1'b0; enable = 1'b0;
    check_dst("R7 block0", 24'h000A00, 24'h000B00, 4);
    check_dst("R7 block1", 24'h000A40, 24'h000B40, 7);
    check_dst("R7 block2", 24'h000A80, 24'h000B80, 2);
    @(negedge clk);

    // R9 stop by clearing enable
    put_entry(24'h000130, 24'h000C00, 24'h000D00, 24'd10);
    prep(24'h000C00, 24'h000D00, 10);
    wr_reg(2'd0, 24'h000130); wr_reg(2'd2, 24'd9);
    block_count = 8'd1; req = 1'b1; enable = 1'b1;
    repeat (17) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 stopped", {31'd0, busy}, 32'd0);
    chk("R9 no done on stop", {31'd0, done}, 32'd0);
    req = 1'b0;
    rd_reg(2'd2, v);
    moved = 10 - int'(v);
    chk("R9 partial progress", {31'd0, (moved > 0 && moved < 10)}, 32'd1);
    rd_reg(2'd0, v); chk("R9 src at stop", {8'd0, v}, 32'h00000C00 + 32'(moved));
    check_dst("R9 partial", 24'h000C00, 24'h000D00, moved);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule